// File: doc/BRIEF.md
# Sleep Mode Clock Gating Controller

This block decides, cycle by cycle, which clock domains of a small controller system receive a clock. The domains are the CPU, data memory, synchronous peripherals (timers and serial units), the ADC and the asynchronous timer. It also drives a run enable for the main oscillator. The CPU puts the system to sleep by pulsing a request strobe while a sleep-enable bit is set. A 3-bit field chooses one of five sleep modes. Each mode keeps its own set of domains clocked and allows its own set of wake sources.

Wake sources are an external interrupt, interrupts from the synchronous peripherals, an asynchronous-timer event and an ADC-complete event. The deepest two modes stop the main oscillator. Waking from one of them holds every domain gated while the oscillator settles, for a start-up count the system programs. The other modes resume on the next cycle. An asynchronous active-low reset leaves any sleep state at once.

Top module: `slp_clkgate_ctrl`

## Requirements
- R1: When `slp_en_i` is 1 and `slp_req_i` is 1 at a rising clock edge while awake, `sleeping_o` is 1 from that edge on, and the enables take the set of the requested mode.
- R2: A request with `slp_en_i` at 0 has no effect. A request while asleep or while waiting for the oscillator also has no effect, and the running mode and its enables stay as they are.
- R3: Mode code 000 is idle. Only the CPU enable is 0 and the oscillator runs. Codes 100, 101 and 111 behave as idle.
- R4: Mode code 001 is ADC noise reduction. Only the ADC and asynchronous-timer enables are 1, and the oscillator runs.
- R5: Mode code 010 is power-down. Every domain enable is 0 and `osc_run_o` is 0.
- R6: Mode code 011 is power-save. Only the asynchronous-timer enable is 1, and `osc_run_o` is 0.
- R7: Mode code 110 is standby. Every domain enable is 0 and the oscillator keeps running.
- R8: The wake inputs are external interrupt, peripheral interrupt, async-timer event and ADC-complete. Idle accepts all four. ADC noise reduction accepts external, async-timer and ADC-complete. Power-save accepts external and async-timer. Power-down and standby accept only the external interrupt. A source that the mode does not accept is ignored.
- R9: An accepted wake in idle, ADC noise reduction or standby makes the system awake at the next edge.
- R10: An accepted wake in power-down or power-save first turns on `osc_run_o` and keeps all domain enables at 0 with `sleeping_o` at 1. The system is awake after N+1 edges, where N is `startup_cnt_i` sampled at the wake edge.
- R11: While `rst_n` is 0, the block is awake at once, with no clock needed: `sleeping_o` is 0, and all enables and `osc_run_o` are 1.
- R12: While awake, every domain enable and `osc_run_o` are 1, and `sleeping_o` is 0.
- Enable bit order: `clk_en_o[0]` CPU, `[1]` memory, `[2]` peripherals, `[3]` ADC, `[4]` asynchronous timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, also a wake source |
| slp_mode_i | input | 3 | Requested sleep mode code |
| slp_en_i | input | 1 | Sleep allowed |
| slp_req_i | input | 1 | Sleep request strobe |
| irq_ext_i | input | 1 | External interrupt |
| irq_per_i | input | 1 | Synchronous peripheral interrupt |
| atmr_evt_i | input | 1 | Asynchronous-timer event |
| adc_done_i | input | 1 | ADC conversion complete |
| startup_cnt_i | input | CNT_W | Oscillator start-up cycles |
| clk_en_o | output | 5 | Per-domain clock enables |
| osc_run_o | output | 1 | Main oscillator run enable |
| sleeping_o | output | 1 | System is in a sleep or start-up state |

## Verification
The properties assume that every input is synchronous to `clk` and steady around the rising edge. The check that an external interrupt in idle wakes the system uses a fact of the block itself: the memory domain is clocked during sleep only in idle. The bench changes all inputs on the falling edge and reads outputs on the next falling edge. The reset case is the one exception: it pulls `rst_n` between edges and checks the asynchronous exit. Random wake vectors mix allowed and disallowed sources, and the last try adds the external interrupt so that every sleep ends.

// File: rtl/slp_pkg.sv
package slp_pkg;

   localparam int N_DOM  = 5;
   localparam int D_CPU  = 0;
   localparam int D_MEM  = 1;
   localparam int D_PER  = 2;
   localparam int D_ADC  = 3;
   localparam int D_ATM  = 4;

   localparam int N_WAKE = 4;
   localparam int W_EXT  = 0;
   localparam int W_PER  = 1;
   localparam int W_ATM  = 2;
   localparam int W_ADC  = 3;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      M_IDLE  = 3'b000,
      M_ADCNR = 3'b001,
      M_PDOWN = 3'b010,
      M_PSAVE = 3'b011,
      M_STBY  = 3'b110
   } slp_mode_e;

   typedef enum logic [1:0] {
      S_RUN   = 2'd0,
      S_SLEEP = 2'd1,
      S_WARM  = 2'd2
   } seq_state_e;

   typedef struct packed {
      logic [N_DOM-1:0]  dom_on;
      logic              osc_on;
      logic              osc_frozen;
      logic [N_WAKE-1:0] wake_ok;
   } mode_cfg_t;

   function automatic slp_mode_e decode_mode(input logic [MODE_W-1:0] code);
      case (code)
         3'b001:  return M_ADCNR;
         3'b010:  return M_PDOWN;
         3'b011:  return M_PSAVE;
         3'b110:  return M_STBY;
         default: return M_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/slp_mode_cfg.sv
module slp_mode_cfg
   import slp_pkg::*;
(
   input  slp_mode_e mode_i,
   output mode_cfg_t cfg_o
);

   always_comb begin
      cfg_o = '0;
      case (mode_i)
         M_ADCNR: begin
            cfg_o.dom_on[D_ADC]  = 1'b1;
            cfg_o.dom_on[D_ATM]  = 1'b1;
            cfg_o.osc_on         = 1'b1;
            cfg_o.wake_ok[W_EXT] = 1'b1;
            cfg_o.wake_ok[W_ATM] = 1'b1;
            cfg_o.wake_ok[W_ADC] = 1'b1;
         end
         M_PDOWN: begin
            cfg_o.osc_frozen     = 1'b1;
            cfg_o.wake_ok[W_EXT] = 1'b1;
         end
         M_PSAVE: begin
            cfg_o.dom_on[D_ATM]  = 1'b1;
            cfg_o.osc_frozen     = 1'b1;
            cfg_o.wake_ok[W_EXT] = 1'b1;
            cfg_o.wake_ok[W_ATM] = 1'b1;
         end
         M_STBY: begin
            cfg_o.osc_on         = 1'b1;
            cfg_o.wake_ok[W_EXT] = 1'b1;
         end
         default: begin
            cfg_o.dom_on         = {N_DOM{1'b1}};
            cfg_o.dom_on[D_CPU]  = 1'b0;
            cfg_o.osc_on         = 1'b1;
            cfg_o.wake_ok        = {N_WAKE{1'b1}};
         end
      endcase
   end

endmodule

// File: rtl/slp_wake_filter.sv
module slp_wake_filter
   import slp_pkg::*;
(
   input  logic [N_WAKE-1:0] evt_i,
   input  logic [N_WAKE-1:0] allow_i,
   output logic              wake_o
);

   logic [N_WAKE-1:0] hit;

   for (genvar w = 0; w < N_WAKE; w++) begin : g_src
      assign hit[w] = evt_i[w] & allow_i[w];
   end

   assign wake_o = |hit;

endmodule

// File: rtl/slp_startup_timer.sv
module slp_startup_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/slp_seq.sv
module slp_seq
   import slp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       slp_en_i,
   input  logic       slp_req_i,
   input  slp_mode_e  req_mode_i,
   input  logic       wake_i,
   input  logic       osc_frozen_i,
   input  logic       timer_expired_i,
   output seq_state_e state_o,
   output slp_mode_e  mode_o,
   output logic       timer_load_o
);

   seq_state_e state_q;
   slp_mode_e  mode_q;

   assign timer_load_o = (state_q == S_SLEEP) && wake_i && osc_frozen_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_RUN;
         mode_q  <= M_IDLE;
      end else begin
         case (state_q)
            S_RUN: begin
               if (slp_en_i && slp_req_i) begin
                  state_q <= S_SLEEP;
                  mode_q  <= req_mode_i;
               end
            end
            S_SLEEP: begin
               if (wake_i) begin
                  state_q <= osc_frozen_i ? S_WARM : S_RUN;
               end
            end
            S_WARM: begin
               if (timer_expired_i) begin
                  state_q <= S_RUN;
               end
            end
            default: state_q <= S_RUN;
         endcase
      end
   end

   assign state_o = state_q;
   assign mode_o  = mode_q;

endmodule

// File: rtl/slp_clkgate_ctrl.sv
module slp_clkgate_ctrl
   import slp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [MODE_W-1:0]   slp_mode_i,
   input  logic                slp_en_i,
   input  logic                slp_req_i,
   input  logic                irq_ext_i,
   input  logic                irq_per_i,
   input  logic                atmr_evt_i,
   input  logic                adc_done_i,
   input  logic [CNT_W-1:0]    startup_cnt_i,
   output logic [N_DOM-1:0]    clk_en_o,
   output logic                osc_run_o,
   output logic                sleeping_o
);

   if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
      $error("slp_clkgate_ctrl: CNT_W must lie in 1..32");
   end

   seq_state_e        state;
   slp_mode_e         mode_q;
   slp_mode_e         req_mode;
   mode_cfg_t         cfg;
   logic [N_WAKE-1:0] evt;
   logic              wake;
   logic              tmr_load;
   logic              tmr_expired;
   logic              in_run;
   logic              in_sleep;

   assign req_mode   = decode_mode(slp_mode_i);
   assign evt[W_EXT] = irq_ext_i;
   assign evt[W_PER] = irq_per_i;
   assign evt[W_ATM] = atmr_evt_i;
   assign evt[W_ADC] = adc_done_i;

   slp_mode_cfg u_cfg (
      .mode_i (mode_q),
      .cfg_o  (cfg)
   );

   slp_wake_filter u_wake (
      .evt_i   (evt),
      .allow_i (cfg.wake_ok),
      .wake_o  (wake)
   );

   slp_startup_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (tmr_load),
      .load_val_i (startup_cnt_i),
      .expired_o  (tmr_expired)
   );

   slp_seq u_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .slp_en_i        (slp_en_i),
      .slp_req_i       (slp_req_i),
      .req_mode_i      (req_mode),
      .wake_i          (wake),
      .osc_frozen_i    (cfg.osc_frozen),
      .timer_expired_i (tmr_expired),
      .state_o         (state),
      .mode_o          (mode_q),
      .timer_load_o    (tmr_load)
   );

   assign in_run   = (state == S_RUN);
   assign in_sleep = (state == S_SLEEP);

   for (genvar d = 0; d < N_DOM; d++) begin : g_dom
      assign clk_en_o[d] = in_run | (in_sleep & cfg.dom_on[d]);
   end

   assign osc_run_o  = ~in_sleep | cfg.osc_on;
   assign sleeping_o = ~in_run;

endmodule

// File: rtl/slp_clkgate_ctrl_chk.sv
module slp_clkgate_ctrl_chk
   import slp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic [MODE_W-1:0]   slp_mode_i,
   input logic                slp_en_i,
   input logic                slp_req_i,
   input logic                irq_ext_i,
   input logic                irq_per_i,
   input logic                atmr_evt_i,
   input logic                adc_done_i,
   input logic [CNT_W-1:0]    startup_cnt_i,
   input logic [N_DOM-1:0]    clk_en_o,
   input logic                osc_run_o,
   input logic                sleeping_o
);

   localparam logic [N_DOM-1:0] NON_ATM = ~(N_DOM'(1) << D_ATM);

   p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleeping_o && slp_en_i && slp_req_i) |=> sleeping_o);

   p_no_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sleeping_o && !slp_en_i) |=> !sleeping_o);

   p_cpu_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sleeping_o |-> !clk_en_o[D_CPU]);

   p_frozen_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_run_o |-> ((clk_en_o & NON_ATM) == '0));

   p_idle_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sleeping_o && clk_en_o[D_MEM] && irq_ext_i) |=> !sleeping_o);

   p_osc_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_en_o[D_CPU]) |-> $past(osc_run_o));

   p_awake_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !sleeping_o |-> ((&clk_en_o) && osc_run_o));

endmodule

bind slp_clkgate_ctrl slp_clkgate_ctrl_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/slp_clkgate_ctrl_test.sv
module slp_clkgate_ctrl_test;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    slp_mode_i = '0;
   logic          slp_en_i = 1'b0;
   logic          slp_req_i = 1'b0;
   logic          irq_ext_i = 1'b0;
   logic          irq_per_i = 1'b0;
   logic          atmr_evt_i = 1'b0;
   logic          adc_done_i = 1'b0;
   logic [CW-1:0] startup_cnt_i = '0;
   logic [4:0]    clk_en_o;
   logic          osc_run_o;
   logic          sleeping_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   slp_clkgate_ctrl #(.CNT_W(CW)) uut (.*);

   always #2.5 clk = ~clk;

   function automatic logic [4:0] exp_mask(input logic [2:0] c);
      case (c)
         3'b001:  return 5'b11000;
         3'b010:  return 5'b00000;
         3'b011:  return 5'b10000;
         3'b110:  return 5'b00000;
         default: return 5'b11110;
      endcase
   endfunction

   function automatic logic exp_osc(input logic [2:0] c);
      return !(c == 3'b010 || c == 3'b011);
   endfunction

   function automatic logic [3:0] exp_wake(input logic [2:0] c);
      case (c)
         3'b001:  return 4'b1101;
         3'b010:  return 4'b0001;
         3'b011:  return 4'b0101;
         3'b110:  return 4'b0001;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic string mode_req(input logic [2:0] c);
      case (c)
         3'b001:  return "R4";
         3'b010:  return "R5";
         3'b011:  return "R6";
         3'b110:  return "R7";
         default: return "R3";
      endcase
   endfunction

   task automatic check(input string req, input logic [6:0] got, input logic [6:0] expv);
      n_chk++;
      if (got !== expv) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b (sleeping,osc,en[4:0])", req, got, expv);
      end
   endtask

   function automatic logic [6:0] obs();
      return {sleeping_o, osc_run_o, clk_en_o};
   endfunction

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   // one sleep episode; ev_first forces the first wake vector when nonzero
   task automatic episode(input logic [2:0] code, input logic en,
                          input int n, input logic [3:0] ev_first);
      logic [6:0] slp_exp;
      logic [3:0] ev;
      logic [3:0] ok;
      startup_cnt_i = CW'(n);
      slp_mode_i = code;
      slp_en_i   = en;
      slp_req_i  = 1'b1;
      step();
      slp_req_i  = 1'b0;
      if (!en) begin
         check("R2", obs(), 7'b0111111);
         return;
      end
      slp_exp = {1'b1, exp_osc(code), exp_mask(code)};
      check({"R1 ", mode_req(code)}, obs(), slp_exp);
      // second request while asleep must not change anything
      slp_mode_i = code ^ 3'b011;
      slp_req_i  = 1'b1;
      step();
      slp_req_i  = 1'b0;
      check("R2", obs(), slp_exp);
      for (int t = 0; t < 6; t++) begin
         ev = (t == 0 && ev_first != 4'b0) ? ev_first : 4'($urandom % 16);
         if (t == 5) ev[0] = 1'b1;
         {adc_done_i, atmr_evt_i, irq_per_i, irq_ext_i} = ev;
         ok = ev & exp_wake(code);
         step();
         {adc_done_i, atmr_evt_i, irq_per_i, irq_ext_i} = 4'b0;
         if (ok == 4'b0) begin
            check("R8", obs(), slp_exp);
         end else begin
            if (!exp_osc(code)) begin
               for (int k = 0; k <= n; k++) begin
                  check("R10", obs(), 7'b1100000);
                  if (k == 0) begin
                     // request during start-up wait is ignored
                     slp_req_i = 1'b1;
                  end
                  step();
                  slp_req_i = 1'b0;
               end
               check("R10", obs(), 7'b0111111);
            end else begin
               check("R9", obs(), 7'b0111111);
            end
            step();
            check("R12", obs(), 7'b0111111);
            return;
         end
      end
   endtask

   initial begin
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      check("R11", obs(), 7'b0111111);
      rst_n = 1'b1;
      step();
      check("R12", obs(), 7'b0111111);

      // directed corner cases
      episode(3'b000, 1'b1, 0, 4'b0010);   // idle, peripheral irq wakes
      episode(3'b001, 1'b1, 0, 4'b0010);   // ADC NR ignores peripheral irq
      episode(3'b001, 1'b1, 0, 4'b1000);   // ADC NR woken by ADC done
      episode(3'b010, 1'b1, 0, 4'b1100);   // power-down ignores timer and ADC
      episode(3'b010, 1'b1, 1, 4'b0001);
      episode(3'b011, 1'b1, 4, 4'b0100);   // power-save woken by async timer
      episode(3'b110, 1'b1, 7, 4'b0100);   // standby ignores timer, no warm-up
      episode(3'b111, 1'b1, 0, 4'b0000);   // unused code acts as idle
      episode(3'b101, 1'b0, 0, 4'b0000);   // enable clear: request ignored

      // reset while in power-down exits at once
      slp_mode_i = 3'b010;
      slp_en_i   = 1'b1;
      slp_req_i  = 1'b1;
      step();
      slp_req_i  = 1'b0;
      check("R5", obs(), 7'b1000000);
      #1 rst_n = 1'b0;
      #0.5 check("R11", obs(), 7'b0111111);
      @(negedge clk);
      rst_n = 1'b1;
      step();
      check("R12", obs(), 7'b0111111);

      // random episodes
      for (int i = 0; i < 80; i++) begin
         episode(3'($urandom % 8), ($urandom % 4) != 0, int'($urandom % 10), 4'b0);
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule